// File: doc/BRIEF.md
# Vectored Fixed-Priority Interrupt Controller

This block gathers forty active-low interrupt lines from on-chip peripherals and hands the processor one request line together with the 32-bit address of the handler slot for the most urgent enabled source. Every line is assigned a recognition type by a parameter. A level-type line asks for service for as long as it is held low. An edge-type line is latched on a high-to-low transition. An edge-type latch stays set until software clears it or the processor acknowledges it while it is the selected source.

Priority is fixed by index, and index 0 is the most urgent. Handler slots are four bytes wide and begin at 0x94. One eight-byte gap sits after index 26, so indices 27 to 39 are moved up by eight bytes. Software uses a single-bit write port to change a source's enable bit or pending bit. A read port returns both bits for any chosen index.

Top module: `irq_vec_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, every pending latch and every enable bit reads 0 and `cpu_req` is 0.
- R2: For a level source, pending reads 1 from the second rising clock edge after its input goes low. It reads 0 again the second edge after the input goes high.
- R3: A software write (`cfg_pend_sel`=1) to a level source's pending bit has no effect, whether it writes 0 or 1.
- R4: An edge source's pending bit sets on the third rising edge after its input falls (two synchronizer stages plus the latch). It stays set after the input rises. A rising input, or an input held low, does not set it.
- R5: For an edge source, a pending write with `cfg_wbit`=1 sets the bit and `cfg_wbit`=0 clears it, taking effect on the next rising edge.
- R6: When `cpu_ack` is high while `cpu_req` is high, it clears the pending bit of the selected source if that source is edge-type. It has no effect on a level source.
- R7: If a detected falling edge coincides with an acknowledge or a software clear of the same source, the pending bit ends up set.
- R8: An enable write (`cfg_pend_sel`=0) stores `cfg_wbit` as the source's enable bit. A source whose enable bit is 0 is never selected. `cpu_req` is 1 exactly when at least one source is both pending and enabled.
- R9: Among enabled pending sources, the one with the lowest index is selected.
- R10: `cpu_vec` is 0x94 + 4*i for selected index i up to 26, and 0x108 + 4*(i-27) for i from 27 to 39. This gives 0xFC for 26, 0x108 for 27 and 0x138 for 39.
- R11: Indices 7, 14, 15, 16, 17, 18, 19, 23 and 24 are edge-type. All others are level-type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n | input | 40 | Active-low peripheral interrupt lines |
| cfg_we | input | 1 | Single-bit configuration write strobe |
| cfg_pend_sel | input | 1 | 1 selects the pending bit, 0 selects the enable bit |
| cfg_idx | input | 6 | Source index targeted by the write |
| cfg_wbit | input | 1 | Value written |
| rd_idx | input | 6 | Source index to read back |
| rd_pend | output | 1 | Pending bit of `rd_idx` |
| rd_en | output | 1 | Enable bit of `rd_idx` |
| cpu_ack | input | 1 | Processor acknowledge strobe |
| cpu_req | output | 1 | Interrupt request to the processor |
| cpu_vec | output | 32 | Handler slot address of the selected source |

## Verification
The bench checks every index across the gap at 26/27. A design that ignores the gap would give 0x100 for index 27 instead of 0x108. It lines up a falling edge in the same cycle as an acknowledge and as a software clear. If the clear were given precedence, the request would be lost and the pending bit would read 0. It writes both 0 and 1 to the pending bits of level sources and acknowledges a level winner. A design that lets those writes through would show a pending bit that no longer matches the line. It also checks that a line held low does not re-trigger an edge source after that source is cleared, which catches a detector that responds to level instead of transition.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned NSRC_DEF      = 40;
  localparam logic [39:0] EDGE_DEF      = 40'h00018FC080;
  localparam logic [31:0] VBASE_DEF     = 32'h0000_0094;
  localparam int unsigned GAP_AFTER_DEF = 26;
  localparam logic [31:0] GAP_BYTES_DEF = 32'd8;

  function automatic logic [31:0] slot_addr(input int unsigned idx,
                                            input logic [31:0] base,
                                            input int unsigned gap_after,
                                            input logic [31:0] gap_bytes);
    logic [31:0] a;
    a = base + 32'(idx) * 32'd4;
    if (idx > gap_after) a = a + gap_bytes;
    return a;
  endfunction
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int unsigned NUM_SRC = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_n,
  output logic               rst_n_int,
  output logic [NUM_SRC-1:0] lvl_n,
  output logic [NUM_SRC-1:0] fall
);
  logic [1:0]         rst_q;
  logic [NUM_SRC-1:0] s1_q, s2_q, prev_q;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_n_int = rst_q[1];

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      s1_q   <= '1;
      s2_q   <= '1;
      prev_q <= '1;
    end else begin
      s1_q   <= irq_n;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign lvl_n = s2_q;
  assign fall  = prev_q & ~s2_q;
endmodule

// File: rtl/irqc_latch.sv
module irqc_latch #(
  parameter int unsigned        NUM_SRC  = 40,
  parameter logic [NUM_SRC-1:0] EDGE_SRC = '0,
  localparam int unsigned       IDX_W    = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] lvl_n,
  input  logic [NUM_SRC-1:0] fall,
  input  logic [NUM_SRC-1:0] ack_clr,
  input  logic               cfg_we,
  input  logic               cfg_pend_sel,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic               cfg_wbit,
  output logic [NUM_SRC-1:0] pend,
  output logic [NUM_SRC-1:0] en
);
  logic [NUM_SRC-1:0] en_q, en_d;

  always_comb begin
    en_d = en_q;
    for (int i = 0; i < NUM_SRC; i++)
      if (cfg_we && !cfg_pend_sel && cfg_idx == IDX_W'(i)) en_d[i] = cfg_wbit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end
  assign en = en_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    if (EDGE_SRC[g]) begin : g_edge
      logic pq, pd, hit, sw_set, sw_clr;
      assign hit    = cfg_we && cfg_pend_sel && (cfg_idx == IDX_W'(g));
      assign sw_set = hit && cfg_wbit;
      assign sw_clr = hit && !cfg_wbit;
      always_comb begin
        pd = pq;
        if (sw_clr || ack_clr[g]) pd = 1'b0;
        if (sw_set || fall[g])    pd = 1'b1;   // edge has the last word
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pq <= 1'b0;
        else        pq <= pd;
      end
      assign pend[g] = pq;

      AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        fall[g] |=> pend[g]);                                  // R7
      AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_clr[g] && !fall[g] && !sw_set) |=> !pend[g]);     // R6
    end else begin : g_level
      assign pend[g] = ~lvl_n[g];
      AST_LEVEL_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_clr[g] && !lvl_n[g]) |-> pend[g]);                // R6
    end
  end
endmodule

// File: rtl/irqc_select.sv
module irqc_select #(
  parameter int unsigned  NUM_SRC   = 40,
  parameter logic [31:0]  VEC_BASE  = 32'h94,
  parameter int unsigned  GAP_AFTER = 26,
  parameter logic [31:0]  GAP_BYTES = 32'd8,
  localparam int unsigned IDX_W     = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] pend,
  input  logic [NUM_SRC-1:0] en,
  output logic               req,
  output logic [IDX_W-1:0]   win,
  output logic [31:0]        vec
);
  import irqc_pkg::*;
  logic [NUM_SRC-1:0] live;

  assign live = pend & en;

  always_comb begin
    win = '0;
    vec = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (live[i]) begin
        win = IDX_W'(i);
        vec = slot_addr(i, VEC_BASE, GAP_AFTER, GAP_BYTES);
      end
    end
  end
  assign req = |live;

  AST_NO_HIGHER_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> ((live & ((NUM_SRC'(1) << win) - NUM_SRC'(1))) == '0)); // R9
  AST_WIN_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> live[win]);                                             // R8
  AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (vec[1:0] == 2'b00 && vec >= VEC_BASE));                // R10
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl #(
  parameter int unsigned        NUM_SRC   = irqc_pkg::NSRC_DEF,
  parameter logic [NUM_SRC-1:0] EDGE_SRC  = irqc_pkg::EDGE_DEF,
  parameter logic [31:0]        VEC_BASE  = irqc_pkg::VBASE_DEF,
  parameter int unsigned        GAP_AFTER = irqc_pkg::GAP_AFTER_DEF,
  parameter logic [31:0]        GAP_BYTES = irqc_pkg::GAP_BYTES_DEF,
  localparam int unsigned       IDX_W     = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_n,
  input  logic               cfg_we,
  input  logic               cfg_pend_sel,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic               cfg_wbit,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic               rd_pend,
  output logic               rd_en,
  input  logic               cpu_ack,
  output logic               cpu_req,
  output logic [31:0]        cpu_vec
);
  localparam int unsigned RD_W = 1 << IDX_W;

  logic               rst_n_int;
  logic [NUM_SRC-1:0] lvl_n, fall, pend, en, ack_clr;
  logic [IDX_W-1:0]   win;
  logic [RD_W-1:0]    pend_ext, en_ext;

  irqc_sync #(.NUM_SRC(NUM_SRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n),
    .rst_n_int(rst_n_int), .lvl_n(lvl_n), .fall(fall));

  irqc_latch #(.NUM_SRC(NUM_SRC), .EDGE_SRC(EDGE_SRC)) u_latch (
    .clk(clk), .rst_n(rst_n_int), .lvl_n(lvl_n), .fall(fall), .ack_clr(ack_clr),
    .cfg_we(cfg_we), .cfg_pend_sel(cfg_pend_sel), .cfg_idx(cfg_idx),
    .cfg_wbit(cfg_wbit), .pend(pend), .en(en));

  irqc_select #(.NUM_SRC(NUM_SRC), .VEC_BASE(VEC_BASE),
                .GAP_AFTER(GAP_AFTER), .GAP_BYTES(GAP_BYTES)) u_sel (
    .clk(clk), .rst_n(rst_n_int), .pend(pend), .en(en),
    .req(cpu_req), .win(win), .vec(cpu_vec));

  assign ack_clr  = (cpu_ack && cpu_req) ? (NUM_SRC'(1) << win) : '0;
  assign pend_ext = RD_W'(pend);
  assign en_ext   = RD_W'(en);
  assign rd_pend  = pend_ext[rd_idx];
  assign rd_en    = en_ext[rd_idx];

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n_int |-> !cpu_req); // R1
  AST_ALL_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n_int)
    (en == '0) |-> !cpu_req);                                              // R8
endmodule

// File: tb/irq_vec_ctrl_test.sv
module irq_vec_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [39:0] irq_n = '1;
  logic        cfg_we = 1'b0, cfg_pend_sel = 1'b0, cfg_wbit = 1'b0, cpu_ack = 1'b0;
  logic [5:0]  cfg_idx = '0, rd_idx = '0;
  logic        rd_pend, rd_en, cpu_req;
  logic [31:0] cpu_vec;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_vec_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .cfg_we(cfg_we),
    .cfg_pend_sel(cfg_pend_sel), .cfg_idx(cfg_idx), .cfg_wbit(cfg_wbit),
    .rd_idx(rd_idx), .rd_pend(rd_pend), .rd_en(rd_en), .cpu_ack(cpu_ack),
    .cpu_req(cpu_req), .cpu_vec(cpu_vec));

  function automatic logic [31:0] exp_vec(input int i);
    if (i <= 26) return 32'h94 + 32'(4 * i);
    return 32'h108 + 32'(4 * (i - 27));
  endfunction

  function automatic bit is_edge(input int i);
    return (i == 7) || (i >= 14 && i <= 19) || (i == 23) || (i == 24);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit pend_sel, input int idx, input bit b);
    cfg_we = 1'b1; cfg_pend_sel = pend_sel; cfg_idx = 6'(idx); cfg_wbit = b;
    tick(1);
    cfg_we = 1'b0;
  endtask

  task automatic pend_of(input int idx, output logic p);
    rd_idx = 6'(idx); #0.1; p = rd_pend;
  endtask

  task automatic t_reset;
    logic p;
    rst_n = 1'b0; tick(3);
    chk(cpu_req == 1'b0, "R1 req in reset", 32'(cpu_req), 0);
    rst_n = 1'b1; tick(4);
    chk(cpu_req == 1'b0, "R1 req after reset", 32'(cpu_req), 0);
    for (int i = 0; i < 40; i++) begin
      rd_idx = 6'(i); #0.1;
      chk(rd_en == 1'b0 && rd_pend == 1'b0, "R1 bits cleared", {30'd0, rd_en, rd_pend}, 0);
    end
    irq_n[0] = 1'b0; tick(3);
    pend_of(0, p);
    chk(p == 1'b1, "R8 pending while disabled", 32'(p), 1);
    chk(cpu_req == 1'b0, "R8 disabled source ignored", 32'(cpu_req), 0);
    irq_n[0] = 1'b1; tick(3);
    for (int i = 0; i < 40; i++) wr(1'b0, i, 1'b1);
    rd_idx = 6'd39; #0.1;
    chk(rd_en == 1'b1, "R8 enable write", 32'(rd_en), 1);
  endtask

  task automatic t_level;
    logic p;
    irq_n[3] = 1'b0; tick(1);
    pend_of(3, p); chk(p == 1'b0, "R2 not yet synced", 32'(p), 0);
    tick(1);
    pend_of(3, p); chk(p == 1'b1, "R2 level pending", 32'(p), 1);
    chk(cpu_vec == exp_vec(3), "R10 vec level 3", cpu_vec, exp_vec(3));
    wr(1'b1, 3, 1'b0);
    pend_of(3, p); chk(p == 1'b1, "R3 clear ignored", 32'(p), 1);
    irq_n[3] = 1'b1; tick(2);
    pend_of(3, p); chk(p == 1'b0, "R2 level released", 32'(p), 0);
    chk(cpu_req == 1'b0, "R2 req drops", 32'(cpu_req), 0);
    wr(1'b1, 3, 1'b1); tick(1);
    pend_of(3, p); chk(p == 1'b0, "R3 set ignored", 32'(p), 0);
  endtask

  task automatic t_edge;
    logic p;
    irq_n[15] = 1'b0; tick(2);
    pend_of(15, p); chk(p == 1'b0, "R4 not yet latched", 32'(p), 0);
    tick(1);
    pend_of(15, p); chk(p == 1'b1, "R4 edge latched", 32'(p), 1);
    wr(1'b1, 15, 1'b0); tick(3);
    pend_of(15, p); chk(p == 1'b0, "R4 held low no retrigger", 32'(p), 0);
    irq_n[15] = 1'b1; tick(4);
    pend_of(15, p); chk(p == 1'b0, "R4 rising ignored", 32'(p), 0);
    irq_n[15] = 1'b0; tick(3); irq_n[15] = 1'b1; tick(4);
    pend_of(15, p); chk(p == 1'b1, "R4 stays after release", 32'(p), 1);
    wr(1'b1, 15, 1'b0);
  endtask

  task automatic t_sw;
    logic p;
    wr(1'b1, 24, 1'b1);
    pend_of(24, p); chk(p == 1'b1, "R5 sw set", 32'(p), 1);
    chk(cpu_vec == exp_vec(24), "R10 vec 24", cpu_vec, exp_vec(24));
    wr(1'b1, 24, 1'b0);
    pend_of(24, p); chk(p == 1'b0, "R5 sw clear", 32'(p), 0);
    chk(cpu_req == 1'b0, "R5 req clear", 32'(cpu_req), 0);
  endtask

  task automatic t_ack;
    logic p;
    wr(1'b1, 18, 1'b1);
    irq_n[20] = 1'b0; tick(3);
    chk(cpu_vec == exp_vec(18), "R9 18 over 20", cpu_vec, exp_vec(18));
    cpu_ack = 1'b1; tick(1); cpu_ack = 1'b0;
    pend_of(18, p); chk(p == 1'b0, "R6 ack clears edge", 32'(p), 0);
    chk(cpu_vec == exp_vec(20), "R6 next winner", cpu_vec, exp_vec(20));
    cpu_ack = 1'b1; tick(1); cpu_ack = 1'b0;
    pend_of(20, p); chk(p == 1'b1, "R6 level survives ack", 32'(p), 1);
    irq_n[20] = 1'b1; tick(3);
  endtask

  task automatic t_conflict;
    logic p;
    wr(1'b1, 16, 1'b1);
    irq_n[16] = 1'b0; tick(2);
    cpu_ack = 1'b1; tick(1); cpu_ack = 1'b0;
    pend_of(16, p); chk(p == 1'b1, "R7 edge beats ack", 32'(p), 1);
    irq_n[16] = 1'b1; wr(1'b1, 16, 1'b0);
    irq_n[17] = 1'b0; tick(2);
    wr(1'b1, 17, 1'b0);
    pend_of(17, p); chk(p == 1'b1, "R7 edge beats sw clear", 32'(p), 1);
    irq_n[17] = 1'b1; wr(1'b1, 17, 1'b0); tick(3);
  endtask

  task automatic t_prio;
    wr(1'b1, 23, 1'b1); wr(1'b1, 14, 1'b1);
    chk(cpu_vec == exp_vec(14), "R9 14 over 23", cpu_vec, exp_vec(14));
    wr(1'b0, 14, 1'b0);
    chk(cpu_vec == exp_vec(23), "R8 disabled skipped", cpu_vec, exp_vec(23));
    wr(1'b0, 14, 1'b1);
    irq_n[0] = 1'b0; tick(2);
    chk(cpu_vec == 32'h94, "R9 source 0 top", cpu_vec, 32'h94);
    irq_n[0] = 1'b1; tick(2);
    wr(1'b1, 14, 1'b0);
    chk(cpu_vec == exp_vec(23), "R9 falls to 23", cpu_vec, exp_vec(23));
    wr(1'b1, 23, 1'b0);
  endtask

  task automatic t_sweep;
    logic p;
    for (int i = 0; i < 40; i++) begin
      wr(1'b1, i, 1'b1);
      pend_of(i, p);
      chk(p == is_edge(i), $sformatf("R11 type of %0d", i), 32'(p), 32'(is_edge(i)));
      irq_n[i] = 1'b0; tick(3);
      chk(cpu_req == 1'b1 && cpu_vec == exp_vec(i), $sformatf("R10 vec %0d", i), cpu_vec, exp_vec(i));
      if (i == 27) chk(cpu_vec == 32'h108, "R10 gap", cpu_vec, 32'h108);
      if (i == 39) chk(cpu_vec == 32'h138, "R10 last", cpu_vec, 32'h138);
      irq_n[i] = 1'b1; tick(2);
      wr(1'b1, i, 1'b0);
      chk(cpu_req == 1'b0, $sformatf("R2 idle after %0d", i), 32'(cpu_req), 0);
    end
  endtask

  initial begin
    tick(1);
    t_reset;
    t_level;
    t_edge;
    t_sw;
    t_ack;
    t_conflict;
    t_prio;
    t_sweep;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule